// File: doc/BRIEF.md
# Result Matrix Readout Serializer

This block streams one stored 4×4 result matrix out of the result memory over a 9-bit bus. Every stored result is an 18-bit word. The block sends each word as two 9-bit beats on consecutive cycles. A full matrix therefore takes 32 beats, and the beats come out back to back.

A host starts a readout by raising the read request while holding the start line low. It also supplies the slot number of the matrix it wants. The request is honoured only while the compute engine reports idle; that is the only arbitration with the compute engine for the shared memory port.

The block latches the slot and fetches the first word, which costs one cycle of memory read latency. It then streams the beats with a strobe and prefetches the next word during the second beat of the current one. One cycle after the last beat it pulses a done flag.

Controller states and transitions:
- IDLE → PRIME when a request is accepted.
- PRIME → STREAM unconditionally; PRIME spends one cycle fetching word 0.
- STREAM stays in STREAM until the second beat of word 15, then goes to FINISH.
- FINISH → IDLE unconditionally; FINISH spends one cycle with done high.
- A synchronous reset returns the controller to IDLE from any state.

Top module: `rdout_serializer`

## Requirements
- R1: A readout is accepted on a rising clock edge in IDLE only when eng_idle=1, rd_req=1 and go_req=0 at that edge. With any other combination, beat_vld and mem_ren stay 0.
- R2: Word k of slot s is read from address s*16+k, where s is the slot_sel value latched at acceptance. Changes to slot_sel after acceptance have no effect on that readout.
- R3: The memory contract is: mem_ren=1 in cycle t makes mem_rdata carry the addressed word from the next cycle on, and mem_rdata holds while mem_ren=0. The block raises mem_ren exactly 16 times per readout: once in the cycle after acceptance (word 0), and once during the second beat of each word k<15 (fetching word k+1).
- R4: Beat 2k carries bits 8:0 of word k and beat 2k+1 carries bits 17:9. The word index k is column-major (k = column*4 + row), so the values leave column by column.
- R5: The first beat appears in the second cycle after the accepting edge. beat_vld is high for exactly 32 consecutive cycles per readout.
- R6: done is high for exactly one cycle, the cycle right after the last beat, with beat_vld low.
- R7: While a readout runs, rd_req, go_req, eng_idle and slot_sel are ignored. The beats, their order and the done timing are unchanged.
- R8: rst is synchronous and active high. While rst is high, beat_vld and done are 0 in the same cycle. After an edge with rst high the block is idle and stays idle until a new accepted request.
- R9: beat_data is 0 whenever beat_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, aborts a readout |
| eng_idle | input | 1 | Compute engine is idle |
| rd_req | input | 1 | Readout request |
| go_req | input | 1 | Compute start line; blocks readout when high |
| slot_sel | input | 5 | Stored matrix slot to read |
| mem_rdata | input | 18 | Result memory read data, one cycle after mem_ren |
| mem_addr | output | 9 | Result memory read address |
| mem_ren | output | 1 | Result memory read enable |
| beat_data | output | 9 | Serialized half-word |
| beat_vld | output | 1 | beat_data carries a valid beat |
| done | output | 1 | One-cycle pulse after the last beat |

## Verification
Every readout is timed from its accepting edge:
- cycle A+1 is the fetch cycle, with mem_ren high, address s*16 and no beat;
- beats 0..31 fall in cycles A+2 through A+33;
- done falls in cycle A+34.

The bench drives inputs on falling edges and samples on the next falling edge, so each expected value is compared in the exact cycle it is due. Each prefetch is checked in the cycle it is issued, against the word index it must carry. For a reset abort, the outputs are sampled shortly after raising rst, before any edge, because beat_vld and done must drop in that same cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRIME  = 2'd1,
        ST_STREAM = 2'd2,
        ST_FINISH = 2'd3
    } rs_state_e;

endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
    import rs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic eng_idle,
    input  logic rd_req,
    input  logic go_req,
    input  logic word_end,
    input  logic last_word,
    output logic load,
    output logic step,
    output logic mem_ren,
    output logic addr_ahead,
    output logic beat_vld,
    output logic done
);

    rs_state_e state, nxt;
    logic      accept;

    assign accept = eng_idle && rd_req && !go_req;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (accept) nxt = ST_PRIME;
            ST_PRIME:  nxt = ST_STREAM;
            ST_STREAM: if (word_end && last_word) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load       = 1'b0;
        step       = 1'b0;
        mem_ren    = 1'b0;
        addr_ahead = 1'b0;
        beat_vld   = 1'b0;
        done       = 1'b0;
        unique case (state)
            ST_IDLE:   load = accept;
            ST_PRIME:  mem_ren = 1'b1;
            ST_STREAM: begin
                step       = 1'b1;
                addr_ahead = 1'b1;
                beat_vld   = !rst;
                mem_ren    = word_end && !last_word;
            end
            ST_FINISH: done = !rst;
        endcase
    end

    // R1: without an accept condition the controller stays in IDLE
    a_r1_idle_needs_accept: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !(eng_idle && rd_req && !go_req)) |=> (state == ST_IDLE));

    // R5: the fetch cycle is followed by streaming
    a_r5_prime_then_stream: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PRIME) |=> (state == ST_STREAM));

    // R6: done only follows the last beat of the last word
    a_r6_finish_after_last: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FINISH) |-> ($past(state) == ST_STREAM && $past(word_end) && $past(last_word)));

    // R7: streaming cannot be restarted by a new request
    a_r7_no_reload_busy: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> !load);

endmodule

// File: rtl/rs_cursor.sv
module rs_cursor #(
    parameter int SLOT_W = 5,
    parameter int VALUES = 16,
    parameter int BEATS  = 2,
    parameter int ADDR_W = 9,
    localparam int IDX_W  = (VALUES > 1) ? $clog2(VALUES) : 1,
    localparam int BSEL_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SLOT_W-1:0] slot_in,
    input  logic              step,
    input  logic              addr_ahead,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BSEL_W-1:0] beat_sel,
    output logic              word_end,
    output logic              last_word
);

    logic [SLOT_W-1:0] slot_q;
    logic [IDX_W-1:0]  word_q;
    logic [BSEL_W-1:0] beat_q;
    logic [IDX_W-1:0]  fetch_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            word_q <= '0;
            beat_q <= '0;
        end else if (load) begin
            slot_q <= slot_in;
            word_q <= '0;
            beat_q <= '0;
        end else if (step) begin
            if (word_end) begin
                beat_q <= '0;
                word_q <= word_q + 1'b1;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    assign word_end  = (beat_q == BSEL_W'(BEATS - 1));
    assign last_word = (word_q == IDX_W'(VALUES - 1));
    assign fetch_idx = addr_ahead ? word_q + 1'b1 : word_q;
    assign mem_addr  = ADDR_W'(slot_q) * ADDR_W'(VALUES) + ADDR_W'(fetch_idx);
    assign beat_sel  = beat_q;

    // R2: latched slot changes only on acceptance
    a_r2_slot_held: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(slot_q));

    // R4: the word index holds until all beats of a word are sent
    a_r4_word_held_midword: assert property (@(posedge clk) disable iff (rst)
        (step && !word_end && !load) |=> $stable(word_q));

endmodule

// File: rtl/rs_lane.sv
module rs_lane #(
    parameter int BEAT_W = 9,
    parameter int BEATS  = 2,
    localparam int WORD_W = BEAT_W * BEATS,
    localparam int BSEL_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic [BSEL_W-1:0] beat_sel,
    input  logic              vld,
    output logic [BEAT_W-1:0] beat_out
);

    logic [BEAT_W-1:0] slices [BEATS];

    for (genvar b = 0; b < BEATS; b++) begin : g_slice
        assign slices[b] = word_in[b*BEAT_W +: BEAT_W];
    end

    always_comb begin
        beat_out = '0;
        if (vld) begin
            for (int b = 0; b < BEATS; b++) begin
                if (beat_sel == BSEL_W'(b)) beat_out = slices[b];
            end
        end
    end

endmodule

// File: rtl/rdout_serializer.sv
module rdout_serializer #(
    parameter int SLOTS  = 32,
    parameter int ROWS   = 4,
    parameter int COLS   = 4,
    parameter int BEAT_W = 9,
    parameter int BEATS  = 2,
    localparam int VALUES = ROWS * COLS,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int ADDR_W = $clog2(SLOTS * VALUES),
    localparam int WORD_W = BEAT_W * BEATS,
    localparam int BSEL_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eng_idle,
    input  logic              rd_req,
    input  logic              go_req,
    input  logic [SLOT_W-1:0] slot_sel,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ren,
    output logic [BEAT_W-1:0] beat_data,
    output logic              beat_vld,
    output logic              done
);

    logic              load, step, addr_ahead, word_end, last_word;
    logic [BSEL_W-1:0] beat_sel;

    rs_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .eng_idle   (eng_idle),
        .rd_req     (rd_req),
        .go_req     (go_req),
        .word_end   (word_end),
        .last_word  (last_word),
        .load       (load),
        .step       (step),
        .mem_ren    (mem_ren),
        .addr_ahead (addr_ahead),
        .beat_vld   (beat_vld),
        .done       (done)
    );

    rs_cursor #(
        .SLOT_W (SLOT_W),
        .VALUES (VALUES),
        .BEATS  (BEATS),
        .ADDR_W (ADDR_W)
    ) u_cursor (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .slot_in    (slot_sel),
        .step       (step),
        .addr_ahead (addr_ahead),
        .mem_addr   (mem_addr),
        .beat_sel   (beat_sel),
        .word_end   (word_end),
        .last_word  (last_word)
    );

    rs_lane #(
        .BEAT_W (BEAT_W),
        .BEATS  (BEATS)
    ) u_lane (
        .word_in  (mem_rdata),
        .beat_sel (beat_sel),
        .vld      (beat_vld),
        .beat_out (beat_data)
    );

    // R3: a prefetch during streaming happens only on a word's final beat
    a_r3_prefetch_on_final_beat: assert property (@(posedge clk) disable iff (rst)
        (mem_ren && beat_vld) |-> (beat_sel == BSEL_W'(BEATS - 1)));

    // R6: done and a beat never coincide
    a_r6_done_apart: assert property (@(posedge clk) disable iff (rst)
        !(done && beat_vld));

endmodule

// File: tb/sim_rdout_serializer.sv
module sim_rdout_serializer;

    logic        clk = 1'b0;
    logic        rst;
    logic        eng_idle, rd_req, go_req;
    logic [4:0]  slot_sel;
    logic [17:0] mem_rdata;
    logic [8:0]  mem_addr;
    logic        mem_ren;
    logic [8:0]  beat_data;
    logic        beat_vld, done;

    int vectors = 0;
    int miscompares = 0;

    always #10 clk = ~clk;

    rdout_serializer u0 (
        .clk       (clk),
        .rst       (rst),
        .eng_idle  (eng_idle),
        .rd_req    (rd_req),
        .go_req    (go_req),
        .slot_sel  (slot_sel),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_ren   (mem_ren),
        .beat_data (beat_data),
        .beat_vld  (beat_vld),
        .done      (done)
    );

    function automatic logic [17:0] model(input int a);
        return 18'((a * 2713 + 341) ^ (a << 9));
    endfunction

    // memory model: one cycle latency, holds when not enabled
    always @(posedge clk) begin
        if (mem_ren) mem_rdata <= model(int'(mem_addr));
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    task automatic read_slot(input int s, input bit noise);
        int ren_cnt;
        logic [17:0] w;
        @(negedge clk);
        slot_sel = 5'(s); rd_req = 1'b1; eng_idle = 1'b1; go_req = 1'b0;
        @(negedge clk);  // fetch cycle
        check("R5 no beat in fetch cycle", int'(beat_vld), 0);
        check("R3 fetch of word 0", int'(mem_ren), 1);
        check("R2 address of word 0", int'(mem_addr), s * 16);
        check("R9 zero data when idle", int'(beat_data), 0);
        ren_cnt = 1;
        slot_sel = 5'(s ^ 5);
        if (noise) begin
            eng_idle = 1'b0; go_req = 1'b1;
        end else begin
            rd_req = 1'b0;
        end
        for (int j = 0; j < 32; j++) begin
            @(negedge clk);
            w = model(s * 16 + j / 2);
            check("R5 beat valid", int'(beat_vld), 1);
            check(noise ? "R7 beat under noise" : "R4 beat content",
                  int'(beat_data), (j % 2) ? int'(w[17:9]) : int'(w[8:0]));
            if (mem_ren) begin
                ren_cnt++;
                check("R3 prefetch on second beat", j % 2, 1);
                check("R2 prefetch address", int'(mem_addr), s * 16 + j / 2 + 1);
            end
            if (noise && j == 10) begin
                eng_idle = 1'b1; go_req = 1'b0; slot_sel = 5'(s + 1);
            end
        end
        @(negedge clk);
        check("R6 done after last beat", int'(done), 1);
        check("R6 no beat with done", int'(beat_vld), 0);
        check("R3 fetch count", ren_cnt, 16);
        rd_req = 1'b0; eng_idle = 1'b1; go_req = 1'b0;
        @(negedge clk);
        check("R6 done single cycle", int'(done), 0);
        check("R7 no restart", int'(beat_vld), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        rst = 1'b1; eng_idle = 1'b1; rd_req = 1'b0; go_req = 1'b0; slot_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset beat_vld", int'(beat_vld), 0);
        check("R8 reset done", int'(done), 0);
        check("R8 reset mem_ren", int'(mem_ren), 0);
        check("R9 reset data", int'(beat_data), 0);
        rst = 1'b0;

        // R1: rejected requests
        eng_idle = 1'b0; rd_req = 1'b1; slot_sel = 5'd3;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1 busy engine blocks", int'(beat_vld | mem_ren), 0);
        end
        eng_idle = 1'b1; go_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1 start line blocks", int'(beat_vld | mem_ren), 0);
        end
        go_req = 1'b0; rd_req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 no request", int'(beat_vld | mem_ren), 0);
        end

        // sweep every slot, alternating quiet and noisy inputs
        for (int s = 0; s < 32; s++) read_slot(s, s[0]);

        // R8: abort mid-stream
        @(negedge clk);
        slot_sel = 5'd5; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        repeat (7) @(negedge clk);
        check("R8 streaming before abort", int'(beat_vld), 1);
        rst = 1'b1;
        #1;
        check("R8 beat_vld drops at once", int'(beat_vld), 0);
        check("R8 done low in reset", int'(done), 0);
        check("R9 data zero in reset", int'(beat_data), 0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check("R8 idle after abort", int'(beat_vld | done), 0);
        end
        read_slot(7, 1'b0);
        read_slot(31, 1'b1);

        summary();
    end

endmodule